// File: doc/BRIEF.md
# Maskable Latched Interrupt Generator

This block gathers single-cycle fault events from several sources into a latched status word and turns them into one interrupt request line for a host. Each source has its own mask bit. A source whose mask bit is set is still recorded in the status word but never raises the request. The host finds the cause by reading the status word, and that read clears every latched bit in one step.

The request line can be programmed to run in one of three styles. It can give one fixed-width pulse, a repeating pulse train that runs until the host reads the status, or a level that follows the unmasked pending bits. Its asserted level can be low or high. It can also be driven open-drain, so that it only ever pulls low and several devices can share one wired-AND line. The line is presented as a value plus an output enable, and pad placement is left to the surrounding chip.

The host reaches the block through a small register port with write and read strobes. There are three registers: the mask, a configuration word, and the read-only status word.

Top module: `irq_latched_ctrl`

## Requirements
- R1: The request is raised only by an event whose mask bit (register address 0, 1 = masked) is 0. A masked event leaves the output at its inactive level.
- R2: Every event sets its status bit (address 2) whether masked or not, and the bit stays set until a clearing read.
- R3: A read strobe at address 2 returns the status as it stood before the read, and clears all bits at the next clock edge.
- R4: Configuration bit 0 (address 1) selects the asserted level: 0 means low is asserted, 1 means high is asserted.
- R5: With configuration bits [2:1] at 00 or 11, an unmasked event produces one pulse of PULSE_CYCLES clock cycles. It starts in the cycle after the event, and an unmasked event during the pulse restarts its width.
- R6: With bits [2:1] at 01, an unmasked event starts a train: asserted for PULSE_CYCLES, released for PULSE_CYCLES, repeating. The train stops, with the output inactive, from the cycle after a clearing read.
- R7: With bits [2:1] at 10, the output is asserted from the cycle after an unmasked event for as long as any unmasked status bit is set.
- R8: With configuration bit 3 at 1 (open-drain), the block never drives a high level. It drives low when the line should read low and disables the output otherwise.
- R9: An event arriving in the same cycle as a clearing read stays latched after that read.
- R10: Writes to address 2 have no effect on the status word.
- R11: After reset the mask reads all ones, the configuration reads 0, the status reads 0, and the output drives high with the enable on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | NUM_SRC | Single-cycle fault event per source |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears status at address 2) |
| addr | input | 2 | Register address: 0 mask, 1 configuration, 2 status |
| wdata | input | NUM_SRC | Write data |
| rdata | output | NUM_SRC | Read data for the addressed register, combinational |
| irq_o | output | 1 | Interrupt line value |
| irq_oe | output | 1 | Interrupt line output enable |

## Verification
The assertions assume that the mask and the configuration word stay unchanged while a pulse or train is running. They also assume that no write to the mask coincides with an event in level mode, because a mode or mask change in mid-pulse could legitimately raise the line without a fresh event. The directed stimulus respects this by rewriting configuration only while the line is idle and the status has been cleared. Events are always driven as synchronous one-cycle pulses away from the clock edge.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [1:0] {
    EV_SINGLE = 2'b00,
    EV_TRAIN  = 2'b01,
    EV_LEVEL  = 2'b10,
    EV_RSVD   = 2'b11
  } ev_mode_e;

  // bit 3: open-drain, bits 2:1: event style, bit 0: active-high
  typedef struct packed {
    logic     od;
    ev_mode_e mode;
    logic     pol;
  } irq_cfg_t;

  localparam int unsigned CFG_W = 4;

  localparam logic [1:0] ADDR_MASK = 2'd0;
  localparam logic [1:0] ADDR_CFG  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  function automatic logic is_single(input ev_mode_e m);
    return (m == EV_SINGLE) || (m == EV_RSVD);
  endfunction

endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [1:0]         addr,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] rdata,
  output logic [NUM_SRC-1:0] mask_o,
  output irq_cfg_t           cfg_o,
  output logic [NUM_SRC-1:0] stat_o,
  output logic               clr_o
);

  localparam int unsigned PAD_W = NUM_SRC - CFG_W;

  logic [NUM_SRC-1:0] mask_q, mask_d;
  logic [NUM_SRC-1:0] stat_q, stat_d;
  irq_cfg_t           cfg_q, cfg_d;
  logic               mask_en, cfg_en, stat_en, clr;

  always_comb begin
    mask_en = wr_en && (addr == ADDR_MASK);
    cfg_en  = wr_en && (addr == ADDR_CFG);
    clr     = rd_en && (addr == ADDR_STAT);
    stat_en = clr || (|evt_i);
    mask_d  = wdata;
    cfg_d   = irq_cfg_t'(wdata[CFG_W-1:0]);
    stat_d  = (clr ? '0 : stat_q) | evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      cfg_q  <= '0;
      stat_q <= '0;
    end else begin
      if (mask_en) mask_q <= mask_d;
      if (cfg_en)  cfg_q  <= cfg_d;
      if (stat_en) stat_q <= stat_d;
    end
  end

  always_comb begin
    case (addr)
      ADDR_MASK: rdata = mask_q;
      ADDR_CFG:  rdata = {{PAD_W{1'b0}}, cfg_q};
      ADDR_STAT: rdata = stat_q;
      default:   rdata = '0;
    endcase
  end

  assign mask_o = mask_q;
  assign cfg_o  = cfg_q;
  assign stat_o = stat_q;
  assign clr_o  = clr;

  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_STAT && evt_i == '0) |=> (stat_q == '0)); // R3

  AST_EVT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i))); // R9

  AST_STATUS_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_STAT && !rd_en && evt_i == '0) |=> $stable(stat_q)); // R10

endmodule

// File: rtl/irq_pulse_gen.sv
module irq_pulse_gen
  import irq_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 24576
) (
  input  logic     clk,
  input  logic     rst_n,
  input  ev_mode_e mode,
  input  logic     trig,
  input  logic     stop,
  input  logic     pending,
  output logic     act
);

  localparam int unsigned CNT_W = (2 * PULSE_CYCLES > 1) ? $clog2(2 * PULSE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] HI_LAST  = CNT_W'(PULSE_CYCLES - 1);
  localparam logic [CNT_W-1:0] PER_LAST = CNT_W'(2 * PULSE_CYCLES - 1);
  localparam logic [CNT_W-1:0] HI_LEN   = CNT_W'(PULSE_CYCLES);

  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             single;

  always_comb begin
    single = is_single(mode);
    run_d  = run_q;
    cnt_d  = cnt_q;
    if (mode == EV_LEVEL) begin
      run_d = 1'b0;
      cnt_d = '0;
    end else if (trig) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else if (run_q) begin
      if (single) begin
        if (cnt_q == HI_LAST) run_d = 1'b0;
        else                  cnt_d = cnt_q + 1'b1;
      end else if (stop) begin
        run_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = (cnt_q == PER_LAST) ? '0 : cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    case (mode)
      EV_LEVEL: act = pending;
      EV_TRAIN: act = run_q && (cnt_q < HI_LEN);
      default:  act = run_q;
    endcase
  end

  AST_TRAIN_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == EV_TRAIN && stop && !trig) |=> !act); // R6

  AST_SINGLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (single && run_q && cnt_q != HI_LAST) |=> run_q); // R5

endmodule

// File: rtl/irq_pad_drive.sv
module irq_pad_drive (
  input  logic act,
  input  logic pol,
  input  logic od,
  output logic out,
  output logic oe
);

  always_comb begin
    if (od) begin
      out = 1'b0;
      oe  = pol ? !act : act;
    end else begin
      out = pol ? act : !act;
      oe  = 1'b1;
    end
  end

endmodule

// File: rtl/irq_latched_ctrl.sv
module irq_latched_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned NUM_SRC      = 8,
  parameter int unsigned PULSE_CYCLES = 24576
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [1:0]         addr,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] rdata,
  output logic               irq_o,
  output logic               irq_oe
);

  logic               rst_s0, rst_s_n;
  logic [NUM_SRC-1:0] mask, stat;
  irq_cfg_t           cfg;
  logic               clr, trig, pending, act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0  <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      rst_s0  <= 1'b1;
      rst_s_n <= rst_s0;
    end
  end

  irq_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .evt_i  (evt_i),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .mask_o (mask),
    .cfg_o  (cfg),
    .stat_o (stat),
    .clr_o  (clr)
  );

  assign trig    = |(evt_i & ~mask);
  assign pending = |(stat & ~mask);

  irq_pulse_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .mode    (cfg.mode),
    .trig    (trig),
    .stop    (clr),
    .pending (pending),
    .act     (act)
  );

  irq_pad_drive u_pad (
    .act (act),
    .pol (cfg.pol),
    .od  (cfg.od),
    .out (irq_o),
    .oe  (irq_oe)
  );

  AST_ONLY_UNMASKED: assert property (@(posedge clk) disable iff (!rst_s_n)
    (is_single(cfg.mode) && $rose(act)) |-> $past(|(evt_i & ~mask))); // R1

  AST_LEVEL_RISES: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cfg.mode == EV_LEVEL && !wr_en && (|(evt_i & ~mask))) |=> act); // R7

  AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_s_n)
    cfg.od |-> !(irq_oe && irq_o)); // R8

endmodule

// File: tb/test_irq_latched_ctrl.sv
module test_irq_latched_ctrl;

  localparam int N = 8;
  localparam int P = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] evt_i;
  logic         wr_en, rd_en;
  logic [1:0]   addr;
  logic [N-1:0] wdata;
  logic [N-1:0] rdata;
  logic         irq_o, irq_oe;

  int n_vec  = 0;
  int n_fail = 0;
  logic b_pol = 1'b0;
  logic b_od  = 1'b0;

  always #5 clk = ~clk;

  irq_latched_ctrl #(.NUM_SRC(N), .PULSE_CYCLES(P)) i_irq_latched_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .irq_oe(irq_oe)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // expected {oe,out} for a wanted asserted state
  task automatic check_pin(input string req, input logic asserted);
    logic lvl;
    logic [1:0] exp;
    lvl = (asserted == b_pol);
    if (b_od) exp = lvl ? 2'b00 : 2'b10;
    else      exp = {1'b1, lvl};
    check(req, {30'd0, irq_oe, irq_o}, {30'd0, exp});
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [N-1:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic set_cfg(input logic od, input logic [1:0] mode, input logic pol);
    b_od = od; b_pol = pol;
    reg_write(2'd1, {{(N-4){1'b0}}, od, mode, pol});
  endtask

  task automatic fire(input logic [N-1:0] v);
    @(negedge clk); evt_i = v;
    @(negedge clk); evt_i = '0;
  endtask

  task automatic t_reset();
    logic [N-1:0] d;
    check_pin("R11 idle pin", 1'b0);
    check("R11 pin high", {31'd0, irq_o}, 32'd1);
    reg_read(2'd0, d); check("R11 mask", {24'd0, d}, 32'hFF);
    reg_read(2'd1, d); check("R11 cfg", {24'd0, d}, 32'h0);
    reg_read(2'd2, d); check("R11 status", {24'd0, d}, 32'h0);
  endtask

  task automatic t_masked();
    logic [N-1:0] d;
    fire(8'h04);
    for (int i = 0; i < 6; i++) begin
      check_pin("R1 masked quiet", 1'b0);
      @(negedge clk);
    end
    reg_read(2'd2, d); check("R2 masked latched", {24'd0, d}, 32'h04);
    reg_read(2'd2, d); check("R3 cleared", {24'd0, d}, 32'h0);
  endtask

  task automatic single_pulse(input string req);
    logic [N-1:0] d;
    fire(8'h01);
    for (int i = 0; i < P; i++) begin
      check_pin(req, 1'b1);
      @(negedge clk);
    end
    check_pin(req, 1'b0);
    reg_read(2'd2, d);
  endtask

  task automatic t_single();
    reg_write(2'd0, 8'h00);
    set_cfg(1'b0, 2'b00, 1'b0);
    single_pulse("R5 single low");
    set_cfg(1'b0, 2'b00, 1'b1);
    single_pulse("R4 active high");
    set_cfg(1'b0, 2'b11, 1'b1);
    single_pulse("R5 code11");
  endtask

  task automatic t_retrigger();
    logic [N-1:0] d;
    set_cfg(1'b0, 2'b00, 1'b1);
    fire(8'h02);
    @(negedge clk);
    fire(8'h02);
    for (int i = 0; i < P; i++) begin
      check_pin("R5 retrigger", 1'b1);
      @(negedge clk);
    end
    check_pin("R5 retrigger end", 1'b0);
    reg_read(2'd2, d);
  endtask

  task automatic t_train();
    logic [N-1:0] d;
    set_cfg(1'b0, 2'b01, 1'b1);
    fire(8'h10);
    for (int c = 0; c < 4 * P; c++) begin
      check_pin("R6 train", (c % (2 * P)) < P);
      @(negedge clk);
    end
    reg_read(2'd2, d);
    check("R6 status", {24'd0, d}, 32'h10);
    for (int i = 0; i < 3 * P; i++) begin
      check_pin("R6 stopped", 1'b0);
      @(negedge clk);
    end
  endtask

  task automatic t_level();
    logic [N-1:0] d;
    set_cfg(1'b0, 2'b10, 1'b0);
    fire(8'h08);
    for (int i = 0; i < 3 * P; i++) begin
      check_pin("R7 level held", 1'b1);
      @(negedge clk);
    end
    reg_read(2'd2, d);
    check_pin("R7 level release", 1'b0);
    reg_write(2'd0, 8'h08);
    fire(8'h08);
    check_pin("R1 level masked", 1'b0);
    reg_read(2'd2, d); check("R2 level masked latched", {24'd0, d}, 32'h08);
    reg_write(2'd0, 8'h00);
  endtask

  task automatic t_open_drain();
    logic [N-1:0] d;
    set_cfg(1'b1, 2'b00, 1'b0);
    check("R8 od low idle", {30'd0, irq_oe, irq_o}, 32'd0);
    fire(8'h01);
    check("R8 od low drive", {30'd0, irq_oe, irq_o}, 32'd2);
    repeat (P) @(negedge clk);
    reg_read(2'd2, d);
    set_cfg(1'b1, 2'b00, 1'b1);
    check("R8 od high idle", {30'd0, irq_oe, irq_o}, 32'd2);
    fire(8'h01);
    check("R8 od high release", {30'd0, irq_oe, irq_o}, 32'd0);
    repeat (P) @(negedge clk);
    reg_read(2'd2, d);
  endtask

  task automatic t_same_cycle();
    logic [N-1:0] d;
    set_cfg(1'b0, 2'b10, 1'b1);
    fire(8'h02);
    @(negedge clk); rd_en = 1'b1; addr = 2'd2; evt_i = 8'h20;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0; evt_i = '0;
    check("R3 pre-clear data", {24'd0, d}, 32'h02);
    check_pin("R9 still pending", 1'b1);
    reg_read(2'd2, d); check("R9 kept", {24'd0, d}, 32'h20);
  endtask

  task automatic t_readonly();
    logic [N-1:0] d;
    reg_write(2'd0, 8'hFF);
    fire(8'h40);
    reg_write(2'd2, 8'h00);
    reg_write(2'd2, 8'hFF);
    reg_read(2'd2, d); check("R10 write ignored", {24'd0, d}, 32'h40);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; evt_i = '0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_masked();
    t_single();
    t_retrigger();
    t_train();
    t_level();
    t_open_drain();
    t_same_cycle();
    t_readonly();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule